// File: doc/BRIEF.md
# Background Subtraction Pixel Classifier

This block sorts each pixel of a small raster frame into foreground or background by comparing it against a stored picture of the empty scene. Pixels arrive one per accepted beat on a valid/ready stream with a frame-start flag. For every pixel of a tracking frame the block emits one object-map bit on a second valid/ready stream, in the same raster order. A bit is 1 when any one colour channel differs from the stored scene by more than a programmable threshold.

The stored scene sits in an internal memory with one 24-bit word per pixel, addressed by raster index. The first frame after reset loads it directly. A training frame blends each new pixel into it with a fixed small weight, so moving clutter fades out over several frames. Training runs only when the mode input asks for it at frame start, or when the block finds that a whole tracking frame was foreground. That condition means the scene has changed and the stored picture is stale.

Back-pressure: `pix_ready` is high whenever the output register is empty or is being drained in the same cycle (`map_ready` high). An input beat is accepted only when `pix_valid` and `pix_ready` are both high. While `map_valid` is high and `map_ready` is low, the output bit is held and no input is taken. Training and seeding frames consume pixels without producing output.

Top module: `bg_subtract_classifier`

## Requirements
- R1: After reset `map_valid` is 0 and `pix_ready` is 1.
- R2: Beats accepted before the first frame start after reset have no effect. The first frame after reset, in either mode, writes each pixel into the stored scene unchanged and produces no output.
- R3: In a training frame each channel of the stored word becomes (13·F + 243·B + 128) >> 8, where F is the new value and B the old. No output is produced.
- R4: In a tracking frame the output bit is 1 if, for R (bits 23:16), G (bits 15:8) or B (bits 7:0), |F − B| is strictly greater than the threshold. Otherwise the bit is 0. The stored scene is left unchanged.
- R5: For each accepted tracking pixel, `map_valid` is high in the following cycle. Bits come out in acceptance order.
- R6: The threshold and the mode (`train_mode` = 1 means training) are captured on the frame-start beat. Changing them later in the frame has no effect on that frame.
- R7: While `map_valid` is high and `map_ready` is low, `pix_ready` is low and `map_bit` holds its value.
- R8: When every pixel of a complete tracking frame is foreground, the next frame is a training frame whatever the mode input says.
- R9: Beats beyond the frame's pixel count are accepted and ignored until the next frame start, which restarts the index at 0.
- R10: A tracking frame cut short by a new frame start never triggers the retraining of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_mode | input | 1 | 1 requests a training frame, 0 a tracking frame; captured at frame start |
| thresh | input | 8 | Per-channel difference threshold; captured at frame start |
| pix_valid | input | 1 | Input pixel beat is valid |
| pix_ready | output | 1 | Block can take an input beat |
| pix_sof | input | 1 | The beat is the first pixel of a frame |
| pix_rgb | input | 24 | Pixel colour, R in 23:16, G in 15:8, B in 7:0 |
| map_valid | output | 1 | Object-map bit is valid |
| map_ready | input | 1 | Consumer takes the object-map bit |
| map_bit | output | 1 | 1 for foreground, 0 for background |

## Verification
The embedded assertions check properties that hold on every cycle. The output bit must hold under stall, and every new output must follow an accepted beat. Retraining may only be armed by the last pixel of a tracking frame. Seeding may only end on a frame start, the raster index must stay within bounds, and a blended channel must fall between the old and new values. Other behaviour depends on sequences across whole frames, so only the bench scenarios show it. These are the seeding of the stored scene, its blending over training frames, and the strict threshold boundary. They also cover mid-frame changes of threshold and mode, the overlong and truncated frames, and the automatic retraining after an all-foreground frame. The bench covers them with its behavioural model of the stored scene.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {
    FK_IDLE  = 2'd0,
    FK_SEED  = 2'd1,
    FK_TRAIN = 2'd2,
    FK_TRACK = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/bgs_chan_unit.sv
module bgs_chan_unit #(
  parameter int CH_W       = 8,
  parameter int ALPHA_NUM  = 13,
  parameter int ALPHA_FRAC = 8
) (
  input  logic [CH_W-1:0] cur_v,
  input  logic [CH_W-1:0] ref_v,
  input  logic [CH_W-1:0] thr_v,
  output logic            exceed,
  output logic [CH_W-1:0] blended
);
  localparam int ACC_W = CH_W + ALPHA_FRAC + 1;
  localparam logic [ACC_W-1:0] K_NEW  = ACC_W'(ALPHA_NUM);
  localparam logic [ACC_W-1:0] K_OLD  = ACC_W'((1 << ALPHA_FRAC) - ALPHA_NUM);
  localparam logic [ACC_W-1:0] K_HALF = ACC_W'(1 << (ALPHA_FRAC - 1));

  logic [CH_W-1:0]  diff;
  logic [ACC_W-1:0] acc;

  always_comb begin
    diff    = (cur_v >= ref_v) ? (cur_v - ref_v) : (ref_v - cur_v);
    exceed  = diff > thr_v;
    acc     = K_NEW * ACC_W'(cur_v) + K_OLD * ACC_W'(ref_v) + K_HALF;
    blended = CH_W'(acc >> ALPHA_FRAC);
  end
endmodule

// File: rtl/bgs_ref_mem.sv
module bgs_ref_mem #(
  parameter int DEPTH  = 4800,
  parameter int DATA_W = 24,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  assign rd_data = store[addr];

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wr_data;
  end

  // R9: ignored beats past the frame end never reach the memory
  a_r9_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/bgs_frame_ctrl.sv
module bgs_frame_ctrl
  import bgs_pkg::*;
#(
  parameter int N_PIX = 4800,
  parameter int IDX_W = 13,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sof,
  input  logic             train_mode,
  input  logic [CH_W-1:0]  thresh,
  input  logic             fg,
  output logic [IDX_W-1:0] cur_idx,
  output logic             in_range,
  output frame_kind_e      cur_kind,
  output logic [CH_W-1:0]  cur_thr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PIX - 1);
  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(N_PIX);

  logic [IDX_W-1:0] nxt_idx_q;
  frame_kind_e      kind_q, new_kind;
  logic [CH_W-1:0]  thr_q;
  logic             seed_pend_q, retrain_q, allfg_q;
  logic             last_pix, run_fg;

  always_comb begin
    if (seed_pend_q)                   new_kind = FK_SEED;
    else if (train_mode || retrain_q)  new_kind = FK_TRAIN;
    else                               new_kind = FK_TRACK;
    cur_kind = sof ? new_kind : kind_q;
    cur_thr  = sof ? thresh : thr_q;
    cur_idx  = sof ? '0 : nxt_idx_q;
    in_range = cur_idx < END_IDX;
    last_pix = cur_idx == LAST_IDX;
    run_fg   = (sof | allfg_q) & fg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_idx_q   <= '0;
      kind_q      <= FK_IDLE;
      thr_q       <= '0;
      seed_pend_q <= 1'b1;
      retrain_q   <= 1'b0;
      allfg_q     <= 1'b0;
    end else if (accept) begin
      if (sof) begin
        kind_q      <= new_kind;
        thr_q       <= thresh;
        seed_pend_q <= 1'b0;
        if (new_kind != FK_TRACK) retrain_q <= 1'b0;
      end
      nxt_idx_q <= in_range ? cur_idx + 1'b1 : cur_idx;
      allfg_q   <= run_fg;
      if (cur_kind == FK_TRACK && last_pix && run_fg) retrain_q <= 1'b1;
    end
  end

  // R8, R10: retraining is armed only by the final pixel of a tracking frame
  a_r8_retrain_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrain_q) |-> $past(accept && cur_kind == FK_TRACK && last_pix));

  // R2: seeding is consumed only by an accepted frame start
  a_r2_seed_once: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seed_pend_q) |-> $past(accept && sof));

  // R9: the raster index saturates at the pixel count
  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_idx_q <= END_IDX);
endmodule

// File: rtl/bg_subtract_classifier.sv
module bg_subtract_classifier
  import bgs_pkg::*;
#(
  parameter int FRAME_W    = 80,
  parameter int FRAME_H    = 60,
  parameter int CH_W       = 8,
  parameter int ALPHA_NUM  = 13,
  parameter int ALPHA_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_mode,
  input  logic [CH_W-1:0]   thresh,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic              pix_sof,
  input  logic [3*CH_W-1:0] pix_rgb,
  output logic              map_valid,
  input  logic              map_ready,
  output logic              map_bit
);
  localparam int N_PIX = FRAME_W * FRAME_H;
  localparam int IDX_W = $clog2(N_PIX + 1);
  localparam int N_CH  = 3;
  localparam int PIX_W = N_CH * CH_W;

  logic              accept, fg, ref_we;
  logic [IDX_W-1:0]  cur_idx;
  logic              in_range;
  frame_kind_e       cur_kind;
  logic [CH_W-1:0]   cur_thr;
  logic [PIX_W-1:0]  ref_word, blend_word, wr_word;
  logic [N_CH-1:0]   ch_exceed;
  logic              map_valid_q, map_bit_q;

  assign pix_ready = !map_valid_q || map_ready;
  assign accept    = pix_valid && pix_ready;
  assign fg        = |ch_exceed;

  bgs_frame_ctrl #(
    .N_PIX (N_PIX),
    .IDX_W (IDX_W),
    .CH_W  (CH_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .sof        (pix_sof),
    .train_mode (train_mode),
    .thresh     (thresh),
    .fg         (fg),
    .cur_idx    (cur_idx),
    .in_range   (in_range),
    .cur_kind   (cur_kind),
    .cur_thr    (cur_thr)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    bgs_chan_unit #(
      .CH_W       (CH_W),
      .ALPHA_NUM  (ALPHA_NUM),
      .ALPHA_FRAC (ALPHA_FRAC)
    ) u_ch (
      .cur_v   (pix_rgb[c*CH_W +: CH_W]),
      .ref_v   (ref_word[c*CH_W +: CH_W]),
      .thr_v   (cur_thr),
      .exceed  (ch_exceed[c]),
      .blended (blend_word[c*CH_W +: CH_W])
    );

    // R3: a blended channel lies between the old and the new value
    a_r3_blend_between: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_range && cur_kind == FK_TRAIN) |->
        ((blend_word[c*CH_W +: CH_W] >= pix_rgb[c*CH_W +: CH_W] &&
          blend_word[c*CH_W +: CH_W] <= ref_word[c*CH_W +: CH_W]) ||
         (blend_word[c*CH_W +: CH_W] <= pix_rgb[c*CH_W +: CH_W] &&
          blend_word[c*CH_W +: CH_W] >= ref_word[c*CH_W +: CH_W])));
  end

  assign ref_we  = accept && in_range &&
                   (cur_kind == FK_SEED || cur_kind == FK_TRAIN);
  assign wr_word = (cur_kind == FK_SEED) ? pix_rgb : blend_word;

  bgs_ref_mem #(
    .DEPTH  (N_PIX),
    .DATA_W (PIX_W),
    .ADDR_W (IDX_W)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ref_we),
    .addr    (cur_idx),
    .wr_data (wr_word),
    .rd_data (ref_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_valid_q <= 1'b0;
      map_bit_q   <= 1'b0;
    end else if (accept && in_range && cur_kind == FK_TRACK) begin
      map_valid_q <= 1'b1;
      map_bit_q   <= fg;
    end else if (map_ready) begin
      map_valid_q <= 1'b0;
    end
  end

  assign map_valid = map_valid_q;
  assign map_bit   = map_bit_q;

  // R7: a stalled output keeps its bit
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_ready) |=> (map_valid && $stable(map_bit)));

  // R5: a fresh output bit always follows an accepted input beat
  a_r5_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(map_valid) |-> $past(pix_valid && pix_ready));
endmodule

// File: tb/bg_subtract_classifier_test.sv
module bg_subtract_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;
  localparam int FH = 6;
  localparam int N  = FW * FH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_mode = 1'b0;
  logic [7:0]  thresh = 8'd0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic        pix_sof = 1'b0;
  logic [23:0] pix_rgb = 24'd0;
  logic        map_valid;
  logic        map_ready = 1'b1;
  logic        map_bit;

  bg_subtract_classifier #(.FRAME_W(FW), .FRAME_H(FH)) uut (
    .clk(clk), .rst_n(rst_n), .train_mode(train_mode), .thresh(thresh),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_sof(pix_sof),
    .pix_rgb(pix_rgb), .map_valid(map_valid), .map_ready(map_ready),
    .map_bit(map_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: 0 idle, 1 seed, 2 train, 3 track
  int    mref [N][3];
  int    m_kind, m_idx, m_thr;
  bit    m_seed_pend, m_retrain, m_allfg, exp_valid, exp_bit;
  int    vectors = 0, miscompares = 0;
  string scen = "R1 reset";
  bit    bp_random = 1'b0;
  int    lfsr = 32'h1234_5679;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_idx = 0; m_thr = 0; m_seed_pend = 1; m_retrain = 0;
      m_allfg = 0; exp_valid = 0; exp_bit = 0;
    end else begin
      bit rdy, acc;
      int idx;
      rdy = !exp_valid || map_ready;
      acc = pix_valid && rdy;
      if (exp_valid && map_ready) exp_valid = 0;
      if (acc) begin
        if (pix_sof) begin
          m_kind = m_seed_pend ? 1 : ((train_mode || m_retrain) ? 2 : 3);
          m_thr = thresh; m_seed_pend = 0;
          if (m_kind != 3) m_retrain = 0;
          m_allfg = 1; idx = 0;
        end else idx = m_idx;
        if (idx < N && m_kind != 0) begin
          bit fg;
          fg = 0;
          for (int c = 0; c < 3; c++) begin
            int f, d;
            f = (pix_rgb >> (8 * (2 - c))) & 255;
            d = f - mref[idx][c];
            if (d < 0) d = -d;
            if (d > m_thr) fg = 1;
            if (m_kind == 1) mref[idx][c] = f;
            else if (m_kind == 2) mref[idx][c] = (13 * f + 243 * mref[idx][c] + 128) / 256;
          end
          if (m_kind == 3) begin
            exp_valid = 1; exp_bit = fg;
            m_allfg = m_allfg && fg;
            if (idx == N - 1 && m_allfg) m_retrain = 1;
          end
        end
        m_idx = (idx < N) ? idx + 1 : idx;
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (pix_ready !== (!exp_valid || map_ready)) begin
      miscompares++;
      $display("FAIL R7 [%s] pix_ready=%b expected %b", scen, pix_ready, !exp_valid || map_ready);
    end
    if (map_valid !== exp_valid) begin
      miscompares++;
      $display("FAIL R5 [%s] map_valid=%b expected %b", scen, map_valid, exp_valid);
    end else if (exp_valid && map_bit !== exp_bit) begin
      miscompares++;
      $display("FAIL R4 [%s] map_bit=%b expected %b", scen, map_bit, exp_bit);
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    map_ready = bp_random ? lfsr[3] : 1'b1;
  end

  function automatic int clamp8(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic logic [23:0] pat(int seed, int i);
    logic [23:0] w;
    for (int c = 0; c < 3; c++) w[8*(2-c) +: 8] = 8'((seed * 37 + i * 13 + c * 71 + seed * i) & 255);
    return w;
  endfunction

  // style 0: pattern(arg); 1: ref + boundary deltas; 2: ref with R flipped; 3: ref + arg on G
  function automatic logic [23:0] make_pix(int style, int arg, int i);
    logic [23:0] w;
    int ii;
    ii = (i < N) ? i : N - 1;
    for (int c = 0; c < 3; c++) w[8*(2-c) +: 8] = 8'(mref[ii][c]);
    case (style)
      0: w = pat(arg, i);
      1: begin
        int dl [6] = '{0, 10, 11, -10, -11, 9};
        int c;
        c = i % 3;
        w[8*(2-c) +: 8] = 8'(clamp8(mref[ii][c] + dl[i % 6]));
      end
      2: w[23:16] = w[23:16] ^ 8'h80;
      default: w[15:8] = 8'(clamp8(mref[ii][1] + arg));
    endcase
    return w;
  endfunction

  task automatic send(input bit sof, input logic [23:0] rgb, input bit gap);
    pix_valid = 1; pix_sof = sof; pix_rgb = rgb;
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    @(posedge clk); #1;
    pix_valid = 0; pix_sof = 0;
    if (gap && lfsr[5]) begin @(posedge clk); #1; end
  endtask

  task automatic frame(input int n, input int style, input int arg, input bit gap,
                       input int chg_at);
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) begin thresh = 8'd0; train_mode = ~train_mode; end
      send(i == 0, make_pix(style, arg, i), gap);
    end
  endtask

  task automatic drain();
    pix_valid = 0;
    repeat (20) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog [%s] run did not end, expected completion", scen);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (map_valid !== 1'b0 || pix_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 reset map_valid=%b pix_ready=%b expected 0 1", map_valid, pix_ready);
    end
    rst_n = 1;
    @(posedge clk); #1;

    scen = "R2 beats before first frame start";
    for (int i = 0; i < 4; i++) send(0, pat(9, i), 0);
    scen = "R2 seed frame in tracking mode";
    train_mode = 0; thresh = 8'd10;
    frame(N, 0, 1, 0, -1);

    scen = "R4 threshold boundary";
    thresh = 8'd10;
    frame(N, 1, 0, 0, -1);

    scen = "R3 training blend";
    train_mode = 1;
    frame(N, 0, 2, 0, -1);
    train_mode = 0;
    scen = "R3 blended scene checked by tracking";
    thresh = 8'd0;
    frame(N, 0, 2, 0, -1);

    scen = "R6 mid-frame threshold and mode change";
    thresh = 8'd20; train_mode = 0;
    frame(N, 3, 15, 0, 10);
    train_mode = 0;

    scen = "R7 back-pressure with gaps";
    bp_random = 1; thresh = 8'd12;
    frame(N, 1, 0, 1, -1);
    frame(N, 0, 5, 1, -1);
    bp_random = 0;
    drain();

    scen = "R10 truncated all-foreground frame";
    thresh = 8'd4;
    frame(N - 5, 2, 0, 0, -1);
    scen = "R10 next frame still tracks";
    frame(N, 1, 0, 0, -1);

    scen = "R8 full all-foreground frame";
    frame(N, 2, 0, 0, -1);
    scen = "R8 forced training frame";
    train_mode = 0;
    frame(N, 0, 7, 0, -1);
    scen = "R8 tracking resumes";
    frame(N, 1, 0, 0, -1);

    scen = "R9 overlong frame";
    thresh = 8'd10;
    for (int i = 0; i < N + 6; i++) send(i == 0, make_pix(1, 0, i % N), 0);
    scen = "R9 index restarts";
    frame(N, 3, 30, 1, -1);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule